// File: doc/BRIEF.md
# BCD Calendar and Clock Counter

This block keeps the time of day and the calendar date. A parameterised binary prescaler counts a 32.768 kHz clock enable. Each time it wraps, it produces a one-second tick, and that tick drives a counter chain. The chain holds seconds, minutes, hours, day of month, day of week, month and a two-digit year. Every field except the month is packed BCD (tens nibble above units nibble). The month is a plain binary value from 1 to 12. Hours follow a 24-hour cycle. Month lengths, including a leap-year February, are derived automatically.

A serial front end that has assembled a new date and time presents it on the preset inputs and pulses the load input. All fields are written in one cycle and the prescaler is cleared. A stop input freezes both the prescaler and the counters. A hold input freezes the parallel outputs so that a reader can capture a consistent snapshot while counting carries on underneath.

Top module: `bcd_calendar_clock`

## Requirements
- R1: The second advances once every 2^DIV_BITS cycles in which `tick_en` is high. Cycles with `tick_en` low do not advance the prescaler.
- R2: Seconds and minutes are packed BCD values from 00 to 59. Seconds step by one on each tick. Both fields wrap from 59 to 00, and each wrap carries into the next field.
- R3: Hours are packed BCD values from 00 to 23. They wrap from 23 to 00, and that wrap advances the date.
- R4: On a date advance, the day of month (packed BCD, starting at 01) returns to 01 after the last day of its month. Months 4, 6, 9 and 11 end on day 30. Months 1, 3, 5, 7, 8, 10 and 12 end on day 31.
- R5: February ends on day 29 when the year's decimal value is a multiple of four. Otherwise it ends on day 28.
- R6: The day of week is a 3-bit binary value from 0 to 6. It advances on every date advance and wraps from 6 to 0.
- R7: The month is a 4-bit binary value from 1 to 12. After the last day of month 12 it becomes 1 and the year advances. The year is packed BCD and wraps from 99 to 00.
- R8: A cycle with `load` high writes every field from the preset inputs and clears the prescaler. The first tick after a load comes a full 2^DIV_BITS enabled cycles later. Load takes priority over counting and stop.
- R9: While `stop` is high, the prescaler and all fields keep their values. Counting resumes from the same prescaler phase when `stop` falls.
- R10: While `hold` is high, the outputs show the values from the cycle before `hold` rose, and counting continues. With `hold` low, the outputs show the live count.
- R11: Reset sets the time to 00:00:00, the day to 01, the day of week to 0, the month to 1 and the year to 00, and clears the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| stop | input | 1 | Freeze prescaler and counters |
| hold | input | 1 | Freeze the output snapshot |
| load | input | 1 | Write all preset fields and clear the prescaler |
| pre_sec | input | 8 | Preset seconds, BCD |
| pre_min | input | 8 | Preset minutes, BCD |
| pre_hour | input | 8 | Preset hours, BCD |
| pre_day | input | 8 | Preset day of month, BCD |
| pre_wday | input | 3 | Preset day of week, 0 to 6 |
| pre_month | input | 4 | Preset month, binary 1 to 12 |
| pre_year | input | 8 | Preset year, BCD |
| sec | output | 8 | Seconds, BCD |
| minute | output | 8 | Minutes, BCD |
| hour | output | 8 | Hours, BCD |
| mday | output | 8 | Day of month, BCD |
| wday | output | 3 | Day of week |
| month | output | 4 | Month, binary |
| year | output | 8 | Year, BCD |

## Verification
The range and month-length assertions assume that every preset is a legal date and time. This means valid BCD digits, hours below 24, a month from 1 to 12, a day that exists in that month and year, and a day of week below 7. Nothing in the block repairs an illegal preset. The bench only ever loads values it builds from integer calendar arithmetic, so every load stays legal. A small prescaler keeps whole sweeps short: two hours of seconds across a year wrap, and the last day of every month of all hundred years.

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock #(
  parameter int DIV_BITS = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       stop,
  input  logic       hold,
  input  logic       load,
  input  logic [7:0] pre_sec,
  input  logic [7:0] pre_min,
  input  logic [7:0] pre_hour,
  input  logic [7:0] pre_day,
  input  logic [2:0] pre_wday,
  input  logic [3:0] pre_month,
  input  logic [7:0] pre_year,
  output logic [7:0] sec,
  output logic [7:0] minute,
  output logic [7:0] hour,
  output logic [7:0] mday,
  output logic [2:0] wday,
  output logic [3:0] month,
  output logic [7:0] year
);

  localparam int SNAP_W = 8 * 5 + 3 + 4;
  localparam logic [SNAP_W-1:0] RESET_VAL = {8'h00, 8'h00, 8'h00, 8'h01, 3'd0, 4'd1, 8'h00};

  logic [DIV_BITS-1:0] div;
  logic [7:0] r_sec, r_min, r_hour, r_day, r_year;
  logic [2:0] r_wday;
  logic [3:0] r_mon;
  logic [SNAP_W-1:0] live, snap, shown;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  wire run      = tick_en && !stop;
  wire tick     = run && (&div);
  wire sec_wrap = r_sec  == 8'h59;
  wire min_wrap = r_min  == 8'h59;
  wire hr_wrap  = r_hour == 8'h23;

  logic [1:0] ymod4;
  assign ymod4 = r_year[1:0] + {r_year[4], 1'b0};
  wire leap = ymod4 == 2'd0;

  logic [7:0] last_day;
  always_comb begin
    case (r_mon)
      4'd2:                    last_day = leap ? 8'h29 : 8'h28;
      4'd4, 4'd6, 4'd9, 4'd11: last_day = 8'h30;
      default:                 last_day = 8'h31;
    endcase
  end

  wire day_wrap = r_day == last_day;
  wire mon_wrap = r_mon == 4'd12;
  wire new_min  = tick && sec_wrap;
  wire new_hour = new_min && min_wrap;
  wire new_date = new_hour && hr_wrap;
  wire new_mon  = new_date && day_wrap;
  wire new_year = new_mon && mon_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div <= '0;
      {r_sec, r_min, r_hour, r_day, r_wday, r_mon, r_year} <= RESET_VAL;
    end else if (load) begin
      div    <= '0;
      r_sec  <= pre_sec;
      r_min  <= pre_min;
      r_hour <= pre_hour;
      r_day  <= pre_day;
      r_wday <= pre_wday;
      r_mon  <= pre_month;
      r_year <= pre_year;
    end else if (run) begin
      div <= div + 1'b1;
      if (tick)     r_sec  <= sec_wrap ? 8'h00 : bcd_inc(r_sec);
      if (new_min)  r_min  <= min_wrap ? 8'h00 : bcd_inc(r_min);
      if (new_hour) r_hour <= hr_wrap  ? 8'h00 : bcd_inc(r_hour);
      if (new_date) begin
        r_day  <= day_wrap ? 8'h01 : bcd_inc(r_day);
        r_wday <= (r_wday == 3'd6) ? 3'd0 : r_wday + 3'd1;
      end
      if (new_mon)  r_mon  <= mon_wrap ? 4'd1 : r_mon + 4'd1;
      if (new_year) r_year <= (r_year == 8'h99) ? 8'h00 : bcd_inc(r_year);
    end
  end

  assign live = {r_sec, r_min, r_hour, r_day, r_wday, r_mon, r_year};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     snap <= RESET_VAL;
    else if (!hold) snap <= live;
  end

  assign shown = hold ? snap : live;
  assign {sec, minute, hour, mday, wday, month, year} = shown;

  AST_SEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    r_sec[3:0] <= 4'd9 && r_sec <= 8'h59 && r_min[3:0] <= 4'd9 && r_min <= 8'h59); // R2
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && tick && sec_wrap) |=> r_sec == 8'h00); // R2
  AST_HOUR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    r_hour[3:0] <= 4'd9 && r_hour <= 8'h23); // R3
  AST_DAY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    r_day != 8'h00 && r_day[3:0] <= 4'd9 && (r_mon == 4'd2 || r_day <= 8'h31)); // R4
  AST_FEB_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (r_mon == 4'd2) |-> (r_day <= (leap ? 8'h29 : 8'h28))); // R5
  AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    r_wday <= 3'd6); // R6
  AST_MONTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    r_mon >= 4'd1 && r_mon <= 4'd12); // R7
  AST_LOAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (r_sec == $past(pre_sec) && r_year == $past(pre_year) && div == '0)); // R8
  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !load) |=> ($stable(div) && $stable(live))); // R9
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!hold || $stable(shown))); // R10

endmodule

// File: tb/tb_bcd_calendar_clock.sv
module tb_bcd_calendar_clock;
  localparam int DB  = 2;
  localparam int PER = 1 << DB;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, stop = 1'b0, hold = 1'b0, load = 1'b0;
  logic [7:0] pre_sec = '0, pre_min = '0, pre_hour = '0, pre_day = 8'h01, pre_year = '0;
  logic [2:0] pre_wday = '0;
  logic [3:0] pre_month = 4'd1;
  logic [7:0] sec, minute, hour, mday, year;
  logic [2:0] wday;
  logic [3:0] month;

  bcd_calendar_clock #(.DIV_BITS(DB)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .stop(stop), .hold(hold), .load(load),
    .pre_sec(pre_sec), .pre_min(pre_min), .pre_hour(pre_hour), .pre_day(pre_day),
    .pre_wday(pre_wday), .pre_month(pre_month), .pre_year(pre_year),
    .sec(sec), .minute(minute), .hour(hour), .mday(mday), .wday(wday),
    .month(month), .year(year));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int ms, mm, mh, md, mw, mo, my;

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int mlen(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic madv();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0;
          mw = (mw + 1) % 7;
          if (md == mlen(mo, my)) begin
            md = 1;
            if (mo == 12) begin mo = 1; my = (my + 1) % 100; end
            else mo++;
          end else md++;
        end
      end
    end
  endtask

  task automatic check(input string req);
    logic [46:0] got, exp;
    got = {sec, minute, hour, mday, wday, month, year};
    exp = {bcd(ms), bcd(mm), bcd(mh), bcd(md), 3'(mw), 4'(mo), bcd(my)};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic preset(input int s, input int m, input int h, input int d,
                        input int w, input int mon, input int y);
    @(negedge clk);
    pre_sec = bcd(s); pre_min = bcd(m); pre_hour = bcd(h); pre_day = bcd(d);
    pre_wday = 3'(w); pre_month = 4'(mon); pre_year = bcd(y);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    ms = s; mm = m; mh = h; md = d; mw = w; mo = mon; my = y;
  endtask

  task automatic run_sec();
    repeat (PER) @(negedge clk);
    madv();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    ms = 0; mm = 0; mh = 0; md = 1; mw = 0; mo = 1; my = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check("R11");
    tick_en = 1'b1;
    repeat (PER - 1) @(negedge clk);
    check("R11");
    @(negedge clk); madv();
    check("R2");

    // R8: full period after load
    preset(56, 34, 12, 15, 3, 7, 21);
    check("R8");
    repeat (PER - 1) @(negedge clk);
    check("R8");
    @(negedge clk); madv();
    check("R8");

    // R1: disabled cycles do not count
    preset(10, 0, 0, 1, 0, 1, 0);
    for (int i = 0; i < PER - 1; i++) begin
      tick_en = 1'b0; @(negedge clk); @(negedge clk);
      tick_en = 1'b1; @(negedge clk);
    end
    check("R1");
    tick_en = 1'b0; repeat (5) @(negedge clk);
    check("R1");
    tick_en = 1'b1; @(negedge clk); madv();
    check("R1");

    // R9: stop freezes and resumes at the same phase
    preset(59, 59, 23, 28, 6, 2, 3);
    @(negedge clk);
    stop = 1'b1;
    repeat (10) @(negedge clk);
    check("R9");
    stop = 1'b0;
    repeat (PER - 2) @(negedge clk);
    check("R9");
    @(negedge clk); madv();
    check("R9");

    // R10: hold freezes outputs while counting continues
    preset(0, 0, 10, 5, 2, 5, 50);
    @(negedge clk);
    hold = 1'b1;
    repeat (3 * PER) @(negedge clk);
    check("R10");
    hold = 1'b0;
    repeat (3) madv();
    #1 check("R10");

    // Two-hour sweep through midnight and a year wrap
    preset(0, 0, 22, 31, 6, 12, 99);
    for (int i = 0; i < 7200; i++) begin
      run_sec();
      if (mh == 0 && mm == 0 && ms == 0) check("R7");
      else if (mm == 0 && ms == 0) check("R3");
      else check("R2");
    end

    // Month-end sweep over every month of every year
    for (int y = 0; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        preset(59, 59, 23, mlen(m, y), (y + m) % 7, m, y);
        run_sec();
        if (m == 2) check("R5");
        else if (m == 12) check("R7");
        else if ((y + m) % 7 == 6) check("R6");
        else check("R4");
      end
      preset(59, 59, 23, 28, 6, 2, y);
      run_sec();
      check("R5");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule